// File: doc/BRIEF.md
# Stereo Sample Mixer and Attenuator

This block is a per-sample preprocessing stage that sits in front of an audio interpolator. Every accepted 32-bit transmit word holds two signed 16-bit samples. The block decides which half is the left channel and which is the right. It can fold the pair into one mono value in one of four ways. It then scales each channel by its own gain in whole-decibel steps, or mutes it. The result leaves as one registered pair of signed 16-bit samples with a valid strobe, two clocks after the word was accepted.

All controls sit in one packed 32-bit configuration register. A write strobe loads the register unless a write-protect input is high. Bits that this stage does not decode are still stored and read back unchanged. The control in force when a sample is accepted travels with that sample down the pipeline, so a register write only affects samples accepted after it.

The pipeline has two register stages. In stage one the channels are chosen and mixed, and the attenuation codes are captured alongside them. In stage two each channel is multiplied by a gain from a table that is computed when the design is elaborated.

Top module: `stereo_mix_atten`

## Requirements
- R1: After reset, `cfg_q` reads 0x00304E4E and `out_valid`, `out_left` and `out_right` are all zero. In that value both attenuation codes are 78, and mono and swap are off.
- R2: When `cfg_we` is high at a clock edge and `wp_en` is low, `cfg_q` takes `cfg_wdata` at that edge. When `cfg_we` and `wp_en` are both high, `cfg_q` keeps its value.
- R3: `out_valid` is high exactly two rising edges after each edge at which `in_valid` was high. Back-to-back input words produce back-to-back outputs.
- R4: With the mono bit (bit 28) clear and the swap bit (bit 19) clear, the left channel is `in_word[15:0]` and the right channel is `in_word[31:16]`, each taken as signed 16-bit.
- R5: With the mono bit clear and the swap bit set, the left channel is `in_word[31:16]` and the right channel is `in_word[15:0]`.
- R6: With the mono bit set and mono mode (bits 30:29) equal to 0, both channels carry floor((L+R)/2). The sum is formed at 17 bits and shifted right arithmetically.
- R7: With the mono bit set and mono mode 1, both channels carry L+R, clamped to the range -32768 to 32767.
- R8: With the mono bit set, mono mode 2 puts `in_word[15:0]` on both channels and mono mode 3 puts `in_word[31:16]` on both channels. The swap bit has no effect in these two modes.
- R9: A channel attenuation code N from 0 to 77 (left in bits 6:0, right in bits 14:8) gives the output (x*G + 16384) >>> 15. Here G = round(32767 * 10^(-N/20)), so G = 32767 when N = 0.
- R10: A channel attenuation code of 78 or more forces that channel's output to zero.
- R11: Each sample uses the configuration held at the edge where it is accepted. A write made one cycle later does not change that sample's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| wp_en | input | 1 | Write protect; while high, writes are dropped |
| cfg_q | output | 32 | Current configuration register value |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 32 | Two signed 16-bit samples |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 16 | Signed left output sample |
| out_right | output | 16 | Signed right output sample |

## Verification
The stereo path is driven with asymmetric pairs whose two halves differ, both with and without swap, so a crossed or unswapped routing shows. The mono average is tried with odd negative sums, where truncating toward zero and flooring give different answers. The saturating sum is tried on both the positive and the negative overflow edges, and the raw-half modes are tried with swap set to show that they bypass it. Attenuation codes 0, 3, 6, 20, 40 and 77 are set unequal between the two channels, and 78 and 127 are used for mute, so swapped codes or a wrong gain entry give a mismatch. Full-scale samples test the rounding at both extremes.

// File: rtl/smx_pkg.sv
package smx_pkg;
    localparam int SAMP_W    = 16;
    localparam int WORD_W    = 2 * SAMP_W;
    localparam int ATT_W     = 7;
    localparam int MUTE_CODE = 78;
    localparam int GAIN_FRAC = 15;
    localparam logic [WORD_W-1:0] CFG_RESET = 32'h0030_4E4E;

    // field positions inside the control word
    localparam int MSEL_LSB = 29;
    localparam int MONO_BIT = 28;
    localparam int SWAP_BIT = 19;
    localparam int ATTR_LSB = 8;
    localparam int ATTL_LSB = 0;

    typedef enum logic [1:0] {
        MONO_AVG     = 2'd0,
        MONO_SUM_SAT = 2'd1,
        MONO_LOW     = 2'd2,
        MONO_HIGH    = 2'd3
    } mono_sel_e;

    typedef struct packed {
        mono_sel_e        mono_sel;
        logic             mono_en;
        logic             swap;
        logic [ATT_W-1:0] att_r;
        logic [ATT_W-1:0] att_l;
    } mix_ctl_t;

    typedef logic [MUTE_CODE-1:0][SAMP_W-1:0] gain_tab_t;

    // 10^(-1/20) in 0.32 fixed point
    localparam logic [127:0] STEP_Q32 = 128'd3827893632;

    // gain[n] = round(32767 * 10^(-n/20)), built by repeated 1 dB steps
    function automatic gain_tab_t smx_gain_table();
        gain_tab_t    tab;
        logic [127:0] acc;
        acc = 128'd32767 << 32;
        for (int n = 0; n < MUTE_CODE; n++) begin
            tab[n] = SAMP_W'((acc + (128'd1 << 31)) >> 32);
            acc    = (acc * STEP_Q32) >> 32;
        end
        return tab;
    endfunction
endpackage

// File: rtl/smx_cfg_reg.sv
module smx_cfg_reg
    import smx_pkg::*;
#(
    parameter int                 W     = WORD_W,
    parameter logic [WORD_W-1:0]  RESET = CFG_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         wp,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output mix_ctl_t     ctl
);
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= W'(RESET);
        else if (we && !wp)  q <= wdata;
    end

    always_comb begin
        ctl.mono_sel = mono_sel_e'(q[MSEL_LSB +: 2]);
        ctl.mono_en  = q[MONO_BIT];
        ctl.swap     = q[SWAP_BIT];
        ctl.att_r    = q[ATTR_LSB +: ATT_W];
        ctl.att_l    = q[ATTL_LSB +: ATT_W];
    end
endmodule

// File: rtl/smx_chan_mix.sv
module smx_chan_mix
    import smx_pkg::*;
#(
    parameter int SW = SAMP_W
) (
    input  logic [2*SW-1:0]  word,
    input  mix_ctl_t         ctl,
    output logic [SW-1:0]    left,
    output logic [SW-1:0]    right
);
    localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};

    logic signed [SW-1:0] lo, hi, ch_l, ch_r, mono_val;
    logic signed [SW:0]   sum;

    always_comb begin
        lo   = word[SW-1:0];
        hi   = word[2*SW-1:SW];
        ch_l = ctl.swap ? hi : lo;
        ch_r = ctl.swap ? lo : hi;
        sum  = (SW+1)'(ch_l) + (SW+1)'(ch_r);

        unique case (ctl.mono_sel)
            MONO_AVG:     mono_val = sum[SW:1];
            MONO_SUM_SAT: begin
                if (sum[SW] != sum[SW-1]) mono_val = sum[SW] ? S_MIN : S_MAX;
                else                      mono_val = sum[SW-1:0];
            end
            MONO_LOW:     mono_val = lo;
            MONO_HIGH:    mono_val = hi;
        endcase

        left  = ctl.mono_en ? mono_val : ch_l;
        right = ctl.mono_en ? mono_val : ch_r;
    end
endmodule

// File: rtl/smx_atten.sv
module smx_atten
    import smx_pkg::*;
#(
    parameter int SW   = SAMP_W,
    parameter int AW   = ATT_W,
    parameter int FRAC = GAIN_FRAC
) (
    input  logic [SW-1:0] sample,
    input  logic [AW-1:0] code,
    output logic [SW-1:0] result
);
    localparam int              PW   = 2 * SW + 2;
    localparam gain_tab_t       TAB  = smx_gain_table();
    localparam logic [PW-1:0]   HALF = PW'(1) << (FRAC - 1);

    logic                 muted;
    logic [AW-1:0]        idx;
    logic signed [SW-1:0] s_in;
    logic signed [PW-1:0] s_ext, g_ext, prod, rnd, shifted;

    always_comb begin
        muted   = (code >= AW'(MUTE_CODE));
        idx     = muted ? '0 : code;
        s_in    = sample;
        s_ext   = PW'(s_in);
        g_ext   = $signed({{(PW-SW){1'b0}}, TAB[idx]});
        prod    = s_ext * g_ext;
        rnd     = prod + $signed(HALF);
        shifted = rnd >>> FRAC;
        result  = muted ? '0 : shifted[SW-1:0];
    end
endmodule

// File: rtl/stereo_mix_atten.sv
module stereo_mix_atten
    import smx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              wp_en,
    output logic [WORD_W-1:0] cfg_q,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [SAMP_W-1:0] out_left,
    output logic [SAMP_W-1:0] out_right
);
    localparam int NCH = 2;

    mix_ctl_t          ctl;
    logic [SAMP_W-1:0] mix_l, mix_r;

    smx_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wp(wp_en),
        .wdata(cfg_wdata), .q(cfg_q), .ctl(ctl)
    );

    smx_chan_mix u_mix (
        .word(in_word), .ctl(ctl), .left(mix_l), .right(mix_r)
    );

    // stage one: mixed pair with the codes captured alongside
    logic                              s1_valid;
    logic [NCH-1:0][SAMP_W-1:0]        s1_samp;
    logic [NCH-1:0][ATT_W-1:0]         s1_code;
    logic [NCH-1:0][SAMP_W-1:0]        att_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_samp  <= '0;
            s1_code  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_samp <= {mix_r, mix_l};
                s1_code <= {ctl.att_r, ctl.att_l};
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        smx_atten u_att (
            .sample(s1_samp[ch]), .code(s1_code[ch]), .result(att_out[ch])
        );
    end

    // stage two: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_left  <= att_out[0];
                out_right <= att_out[1];
            end
        end
    end
endmodule

// File: rtl/smx_checker.sv
module smx_checker
    import smx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              wp_en,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic [WORD_W-1:0] cfg_q,
    input logic              in_valid,
    input logic              out_valid,
    input logic [SAMP_W-1:0] out_left,
    input logic [SAMP_W-1:0] out_right
);
    logic [1:0] since;
    always_ff @(posedge clk) begin
        if (!rst_n)          since <= '0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    a_r2_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wp_en) |=> $stable(cfg_q));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wp_en) |=> (cfg_q == $past(cfg_wdata)));

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r10_mute_left: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2'd2 && out_valid && $past(cfg_q[ATTL_LSB +: ATT_W], 2) >= ATT_W'(MUTE_CODE))
        |-> (out_left == '0));

    a_r10_mute_right: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2'd2 && out_valid && $past(cfg_q[ATTR_LSB +: ATT_W], 2) >= ATT_W'(MUTE_CODE))
        |-> (out_right == '0));

    a_r8_mono_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2'd2 && out_valid && $past(cfg_q[MONO_BIT], 2)
         && $past(cfg_q[ATTL_LSB +: ATT_W], 2) == $past(cfg_q[ATTR_LSB +: ATT_W], 2))
        |-> (out_left == out_right));
endmodule

bind stereo_mix_atten smx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wp_en(wp_en),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .in_valid(in_valid),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
);

// File: tb/stereo_mix_atten_tb.sv
module stereo_mix_atten_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        wp_en = 1'b0;
    logic [31:0] cfg_q;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [15:0] out_left, out_right;

    always #5 clk = ~clk;

    stereo_mix_atten u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wp_en(wp_en), .cfg_q(cfg_q), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    typedef struct {
        int          due;
        logic [15:0] l;
        logic [15:0] r;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [31:0] shadow = 32'h0030_4E4E;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int gain_of(int n);
        return $rtoi(32767.0 * (10.0 ** (-n / 20.0)) + 0.5);
    endfunction

    function automatic logic [15:0] att(int s, int n);
        longint p;
        if (n >= 78) return 16'h0;
        p = longint'(s) * longint'(gain_of(n)) + 64'sd16384;
        return 16'(p >>> 15);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(logic [31:0] w, string tag);
        int lo, hi, l, r, sum, m;
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        lo = int'($signed(w[15:0]));
        hi = int'($signed(w[31:16]));
        l  = shadow[19] ? hi : lo;
        r  = shadow[19] ? lo : hi;
        if (shadow[28]) begin
            sum = l + r;
            case (shadow[30:29])
                2'd0: m = sum >>> 1;
                2'd1: m = (sum > 32767) ? 32767 : ((sum < -32768) ? -32768 : sum);
                2'd2: m = lo;
                default: m = hi;
            endcase
            l = m;
            r = m;
        end
        it.due = cyc + 2;
        it.l   = att(l, int'(shadow[6:0]));
        it.r   = att(r, int'(shadow[14:8]));
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [31:0] d, logic wp);
        logic [31:0] want;
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_wdata = d;
        wp_en     = wp;
        want      = wp ? shadow : d;
        @(negedge clk);
        cfg_we = 1'b0;
        wp_en  = 1'b0;
        check(wp ? "R2 protected write" : "R2 write", 64'(cfg_q), 64'(want));
        shadow = want;
    endtask

    function automatic logic [31:0] mk(logic [1:0] msel, logic mono, logic swp,
                                       logic [6:0] ar, logic [6:0] al);
        return {1'b0, msel, mono, 8'h00, swp, 3'b000, 1'b0, ar, 1'b0, al};
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R3 unexpected out_valid actual=1 expected=0");
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check({it.tag, " R3 latency"}, 64'(cyc), 64'(it.due));
                    check({it.tag, " left"},  64'(out_left),  64'(it.l));
                    check({it.tag, " right"}, 64'(out_right), 64'(it.r));
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                n_chk++; n_bad++;
                $display("FAIL R3 missing out_valid actual=0 expected=1");
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cfg reset", 64'(cfg_q), 64'h0030_4E4E);
        check("R1 valid reset", 64'(out_valid), 64'd0);
        check("R1 data reset", 64'({out_left, out_right}), 64'd0);
        rst_n = 1'b1;

        send(32'h1234_5678, "R10 muted at reset");
        idle(3);

        wr_cfg(mk(2'd0, 1'b0, 1'b0, 7'd0, 7'd0), 1'b1);
        send(32'h2222_1111, "R2 write ignored keeps mute");
        idle(3);

        wr_cfg(mk(2'd0, 1'b0, 1'b0, 7'd0, 7'd0), 1'b0);
        send(32'h7FFF_8000, "R4 stereo full scale");
        send(32'hC000_0123, "R4 stereo mixed");
        send(32'h0001_FFFF, "R4 stereo small");
        idle(3);

        wr_cfg(mk(2'd0, 1'b0, 1'b1, 7'd0, 7'd0), 1'b0);
        send(32'h1000_F000, "R5 swap");
        send(32'h8000_7FFF, "R5 swap extremes");
        idle(3);

        wr_cfg(mk(2'd0, 1'b1, 1'b0, 7'd0, 7'd0), 1'b0);
        send(32'hFFFE_FFFF, "R6 avg odd negative");
        send(32'h0003_0002, "R6 avg odd positive");
        send(32'h8000_8000, "R6 avg min");
        idle(3);

        wr_cfg(mk(2'd1, 1'b1, 1'b0, 7'd0, 7'd0), 1'b0);
        send(32'h7000_7000, "R7 sat positive");
        send(32'h9000_9000, "R7 sat negative");
        send(32'h0100_FF00, "R7 sum no overflow");
        idle(3);

        wr_cfg(mk(2'd2, 1'b1, 1'b1, 7'd0, 7'd0), 1'b0);
        send(32'hABCD_1357, "R8 low half with swap");
        wr_cfg(mk(2'd3, 1'b1, 1'b1, 7'd0, 7'd0), 1'b0);
        send(32'hABCD_1357, "R8 high half with swap");
        idle(3);

        wr_cfg(mk(2'd0, 1'b0, 1'b0, 7'd6, 7'd3), 1'b0);
        send(32'h4000_C000, "R9 gain 3/6 dB");
        wr_cfg(mk(2'd0, 1'b0, 1'b0, 7'd40, 7'd20), 1'b0);
        send(32'h7FFF_8000, "R9 gain 20/40 dB");
        wr_cfg(mk(2'd0, 1'b0, 1'b0, 7'd78, 7'd77), 1'b0);
        send(32'h7FFF_7FFF, "R9 R10 77 dB and mute right");
        wr_cfg(mk(2'd0, 1'b0, 1'b0, 7'd0, 7'd127), 1'b0);
        send(32'h5555_AAAA, "R10 mute left 127");
        idle(3);

        wr_cfg(mk(2'd0, 1'b0, 1'b0, 7'd0, 7'd0), 1'b0);
        send(32'h0102_0304, "R3 burst 0");
        send(32'h0506_0708, "R3 burst 1");
        send(32'h090A_0B0C, "R3 burst 2");
        wr_cfg(mk(2'd3, 1'b1, 1'b0, 7'd78, 7'd78), 1'b0);
        idle(3);
        send(32'h1111_2222, "R11 new config applies");
        idle(4);

        check("R3 queue drained", 64'(sb.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule